// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Software Refill

This block is a small fully associative address translation buffer whose contents are managed entirely by software. Each entry maps two neighbouring virtual pages (an even one and an odd one) onto two independent physical frames. Each half carries its own valid flag, dirty flag and 3-bit cache attribute. The page size is set per entry by a mask. Software stages an entry in five holding registers: a virtual tag/ASID register, two frame registers, a page-size register and an index register. It then issues one of four commands: write at the index, write at a caller-supplied replacement slot, probe, or read back.

A separate lookup port translates a virtual address and address-space identifier on every cycle. The physical address, miss flag, invalid flag, dirty flag and cache attribute appear one clock later. The replacement slot is driven from outside the block, so the decrementing replacement counter lives elsewhere.

There is no multi-cycle sequencing. The command decoder works as a single-state machine that takes one of five named actions each cycle. IDLE leaves the holding registers to software writes. WRITE_AT_INDEX and WRITE_AT_SLOT load the entry array. PROBE updates the index register. READ_BACK reloads the holding registers. Every action goes back to IDLE on the next edge.

Top module: `paired_tlb`

## Requirements
- R1: After reset every entry has a zero tag, zero ASID, global bit clear and both halves invalid, and all holding registers read zero. A lookup of address 0 with ASID 0 therefore reports invalid (not miss), and a probe with a zero tag register returns index 0.
- R2: Command code 0 (WRITE_AT_INDEX) stores an entry at the low log2(N) bits of the index register. The tag comes from tag register bits 31:13 and the ASID from bits 7:0.
- R3: Command code 1 (WRITE_AT_SLOT) stores the entry at the slot given on `slot_idx`, ignoring the index register.
- R4: The stored global bit is bit 0 of the even frame register ANDed with bit 0 of the odd frame register. A global entry matches any ASID, and a non-global entry matches only its own ASID.
- R5: In each frame register, bit 1 is valid, bit 2 is dirty, bits 5:3 are the cache attribute and bits 25:6 are the frame number. The physical page base is the frame number shifted left by 12.
- R6: Page-size register bits 24:13 form a mask M (legal values 2^k-1). The page offset is the low 12 bits plus M placed at bits 23:12. The bit just above the offset selects the odd half. Tag bits under M are not compared.
- R7: Command code 2 (PROBE) on a hit writes the lowest matching entry number into the index register and clears index bit 31.
- R8: A PROBE with no match sets index bit 31 and leaves the index number unchanged.
- R9: Command code 3 (READ_BACK) reloads the tag register as tag|ASID, the page-size register as M<<13, and both frame registers with the global bit in bit 0 and the remaining fields in the positions of R5.
- R10: Lookup results are registered one cycle after the address. On a miss, invalid and dirty are low. On a hit to a half whose valid bit is clear, invalid is high. Dirty and cache attribute come from the selected half.
- R11: When several entries match a lookup, the lowest-numbered entry supplies the translation.
- R12: A lookup presented in the same cycle as a write command uses the array contents from before that edge.
- Register select codes on `csr_sel`: 0 tag, 1 even frame, 2 odd frame, 3 page size, 4 index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Holding register write strobe |
| csr_sel | input | 3 | Holding register select |
| csr_wdata | input | 32 | Holding register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| slot_idx | input | log2(N) | Replacement slot for WRITE_AT_SLOT |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| hi_o | output | 32 | Tag/ASID register |
| lo0_o | output | 32 | Even frame register |
| lo1_o | output | 32 | Odd frame register |
| mask_o | output | 32 | Page-size register |
| index_o | output | 32 | Index register, bit 31 = probe failed |
| lk_paddr | output | 32 | Translated physical address |
| lk_miss | output | 1 | No entry matched |
| lk_invalid | output | 1 | Matched half is not valid |
| lk_dirty | output | 1 | Matched half is dirty |
| lk_cattr | output | 3 | Matched half cache attribute |

## Verification
The lookup port and a write command can act in the same cycle on the entry that the lookup hits. The bench presents a lookup of a mapped address in the very cycle that WRITE_AT_INDEX overwrites that entry. It expects the old translation in the next cycle. One cycle later it expects the translation from a lower-priority duplicate entry. Probe and read-back are also run on entries with duplicate tags, so that the lowest-index rule is judged on both the command path and the lookup path.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int ASID_W  = 8;
    localparam int PMASK_W = 12;
    localparam int PFN_W   = 20;
    localparam int CATTR_W = 3;
    localparam int OFF_W   = 12;
    localparam int VPN2_W  = VA_W - OFF_W - 1;

    typedef enum logic [1:0] {
        OP_WRITE_AT_INDEX = 2'd0,
        OP_WRITE_AT_SLOT  = 2'd1,
        OP_PROBE          = 2'd2,
        OP_READ_BACK      = 2'd3
    } tlb_op_e;

    typedef enum logic [2:0] {
        SEL_TAG   = 3'd0,
        SEL_LO0   = 3'd1,
        SEL_LO1   = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_INDEX = 3'd4
    } csr_sel_e;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [CATTR_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } half_t;

    typedef struct packed {
        half_t h;
        logic  g;
    } frame_reg_t;

    typedef struct packed {
        logic [VPN2_W-1:0]  vpn2;
        logic [ASID_W-1:0]  asid;
        logic [PMASK_W-1:0] pmask;
        logic               g;
        half_t              even;
        half_t              odd;
    } entry_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDXW-1:0]     widx,
    input  entry_t              wdata,
    output entry_t [N-1:0]      ents
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents <= '0;
        end else if (we) begin
            ents[widx] <= wdata;
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N)
) (
    input  entry_t [N-1:0]    ents,
    input  logic [VPN2_W-1:0] vpn2,
    input  logic [ASID_W-1:0] asid,
    output logic              hit,
    output logic [IDXW-1:0]   idx,
    output entry_t            sel
);
    logic [N-1:0] mv;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [VPN2_W-1:0] care;
        assign care  = ~{{(VPN2_W-PMASK_W){1'b0}}, ents[i].pmask};
        assign mv[i] = (((ents[i].vpn2 ^ vpn2) & care) == '0) &&
                       (ents[i].g || (ents[i].asid == asid));
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mv[i]) begin
                hit = 1'b1;
                idx = IDXW'(i);
                sel = ents[i];
            end
        end
    end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int N    = 16,
    parameter int IDXW = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [2:0]         csr_sel,
    input  logic [31:0]        csr_wdata,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [IDXW-1:0]    slot_idx,
    input  logic               probe_hit,
    input  logic [IDXW-1:0]    probe_idx,
    input  entry_t             rd_entry,
    output logic [VPN2_W-1:0]  tag_q,
    output logic [ASID_W-1:0]  asid_q,
    output frame_reg_t         lo0_q,
    output frame_reg_t         lo1_q,
    output logic [PMASK_W-1:0] pmask_q,
    output logic               fail_q,
    output logic [IDXW-1:0]    idx_q,
    output logic               st_we,
    output logic [IDXW-1:0]    st_idx,
    output entry_t             st_wdata
);
    logic [VPN2_W-1:0]  tag_d;
    logic [ASID_W-1:0]  asid_d;
    frame_reg_t         lo0_d, lo1_d;
    logic [PMASK_W-1:0] pmask_d;
    logic               fail_d;
    logic [IDXW-1:0]    idx_d;
    tlb_op_e            op;

    assign op = tlb_op_e'(cmd_op);

    assign st_wdata = '{vpn2: tag_q, asid: asid_q, pmask: pmask_q,
                        g: lo0_q.g & lo1_q.g, even: lo0_q.h, odd: lo1_q.h};

    // register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            asid_q  <= '0;
            lo0_q   <= '0;
            lo1_q   <= '0;
            pmask_q <= '0;
            fail_q  <= 1'b0;
            idx_q   <= '0;
        end else begin
            tag_q   <= tag_d;
            asid_q  <= asid_d;
            lo0_q   <= lo0_d;
            lo1_q   <= lo1_d;
            pmask_q <= pmask_d;
            fail_q  <= fail_d;
            idx_q   <= idx_d;
        end
    end

    // action process
    always_comb begin
        tag_d   = tag_q;
        asid_d  = asid_q;
        lo0_d   = lo0_q;
        lo1_d   = lo1_q;
        pmask_d = pmask_q;
        fail_d  = fail_q;
        idx_d   = idx_q;
        st_we   = 1'b0;
        st_idx  = idx_q;

        if (csr_we) begin
            case (csr_sel_e'(csr_sel))
                SEL_TAG: begin
                    tag_d  = csr_wdata[31:13];
                    asid_d = csr_wdata[7:0];
                end
                SEL_LO0:   lo0_d   = csr_wdata[25:0];
                SEL_LO1:   lo1_d   = csr_wdata[25:0];
                SEL_MASK:  pmask_d = csr_wdata[24:13];
                SEL_INDEX: begin
                    fail_d = csr_wdata[31];
                    idx_d  = csr_wdata[IDXW-1:0];
                end
                default: ;
            endcase
        end

        if (cmd_valid) begin
            unique case (op)
                OP_WRITE_AT_INDEX: begin
                    st_we  = 1'b1;
                    st_idx = idx_q;
                end
                OP_WRITE_AT_SLOT: begin
                    st_we  = 1'b1;
                    st_idx = slot_idx;
                end
                OP_PROBE: begin
                    if (probe_hit) begin
                        fail_d = 1'b0;
                        idx_d  = probe_idx;
                    end else begin
                        fail_d = 1'b1;
                    end
                end
                OP_READ_BACK: begin
                    tag_d   = rd_entry.vpn2;
                    asid_d  = rd_entry.asid;
                    pmask_d = rd_entry.pmask;
                    lo0_d   = '{h: rd_entry.even, g: rd_entry.g};
                    lo1_d   = '{h: rd_entry.odd,  g: rd_entry.g};
                end
            endcase
        end
    end
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDXW = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [2:0]        csr_sel,
    input  logic [31:0]       csr_wdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDXW-1:0]   slot_idx,
    input  logic [31:0]       lk_vaddr,
    input  logic [7:0]        lk_asid,
    output logic [31:0]       hi_o,
    output logic [31:0]       lo0_o,
    output logic [31:0]       lo1_o,
    output logic [31:0]       mask_o,
    output logic [31:0]       index_o,
    output logic [31:0]       lk_paddr,
    output logic              lk_miss,
    output logic              lk_invalid,
    output logic              lk_dirty,
    output logic [2:0]        lk_cattr
);
    entry_t [N_ENTRIES-1:0] ents;
    logic [VPN2_W-1:0]  tag_q;
    logic [ASID_W-1:0]  asid_q;
    frame_reg_t         lo0_q, lo1_q;
    logic [PMASK_W-1:0] pmask_q;
    logic               fail_q;
    logic [IDXW-1:0]    idx_q;
    logic               st_we;
    logic [IDXW-1:0]    st_idx;
    entry_t             st_wdata;
    logic               pr_hit;
    logic [IDXW-1:0]    pr_idx;
    entry_t             pr_ent;
    logic               lk_hit;
    logic [IDXW-1:0]    lk_idx;
    entry_t             lk_ent;
    logic [31:0]        offmask;
    logic               odd_sel;
    half_t              half;
    logic               unused_sink;

    tlb_ctrl #(.N(N_ENTRIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .slot_idx(slot_idx),
        .probe_hit(pr_hit), .probe_idx(pr_idx), .rd_entry(ents[idx_q]),
        .tag_q(tag_q), .asid_q(asid_q), .lo0_q(lo0_q), .lo1_q(lo1_q),
        .pmask_q(pmask_q), .fail_q(fail_q), .idx_q(idx_q),
        .st_we(st_we), .st_idx(st_idx), .st_wdata(st_wdata)
    );

    tlb_store #(.N(N_ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .widx(st_idx),
        .wdata(st_wdata), .ents(ents)
    );

    tlb_match #(.N(N_ENTRIES)) u_probe (
        .ents(ents), .vpn2(tag_q), .asid(asid_q),
        .hit(pr_hit), .idx(pr_idx), .sel(pr_ent)
    );

    tlb_match #(.N(N_ENTRIES)) u_lookup (
        .ents(ents), .vpn2(lk_vaddr[31:13]), .asid(lk_asid),
        .hit(lk_hit), .idx(lk_idx), .sel(lk_ent)
    );

    assign unused_sink = ^{pr_ent, lk_idx, lk_ent.vpn2, lk_ent.asid, lk_ent.g};

    assign hi_o    = {tag_q, 5'b0, asid_q};
    assign lo0_o   = {6'b0, lo0_q};
    assign lo1_o   = {6'b0, lo1_q};
    assign mask_o  = {7'b0, pmask_q, 13'b0};
    assign index_o = {fail_q, {(31-IDXW){1'b0}}, idx_q};

    assign offmask = {8'b0, lk_ent.pmask, 12'hFFF};
    assign odd_sel = |(lk_vaddr & (offmask + 32'd1));
    assign half    = odd_sel ? lk_ent.odd : lk_ent.even;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_paddr   <= '0;
            lk_miss    <= 1'b1;
            lk_invalid <= 1'b0;
            lk_dirty   <= 1'b0;
            lk_cattr   <= '0;
        end else begin
            lk_paddr   <= ({half.pfn, 12'b0} & ~offmask) | (lk_vaddr & offmask);
            lk_miss    <= !lk_hit;
            lk_invalid <= lk_hit && !half.valid;
            lk_dirty   <= lk_hit && half.dirty;
            lk_cattr   <= lk_hit ? half.cattr : '0;
        end
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int IDXW = $clog2(N_ENTRIES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [1:0]             cmd_op,
    input logic                   pr_hit,
    input logic [IDXW-1:0]        pr_idx,
    input logic [31:0]            index_o,
    input logic [31:0]            hi_o,
    input logic [31:0]            lo0_o,
    input logic [31:0]            lo1_o,
    input logic                   lk_miss,
    input logic                   lk_invalid,
    input logic                   lk_dirty,
    input entry_t [N_ENTRIES-1:0] ents
);
    // R8
    probe_miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && !pr_hit) |=> index_o[31]);

    // R7
    probe_hit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && pr_hit) |=>
        (index_o == {{(32-IDXW){1'b0}}, $past(pr_idx)}));

    // R10
    miss_excludes_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (!lk_invalid && !lk_dirty));

    // R9
    readback_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3) |=> (lo0_o[0] == lo1_o[0]));

    // R2
    write_index_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |=>
        (ents[$past(index_o[IDXW-1:0])].vpn2 == $past(hi_o[31:13]) &&
         ents[$past(index_o[IDXW-1:0])].asid == $past(hi_o[7:0])));

    // R4
    write_global_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |=>
        (ents[$past(index_o[IDXW-1:0])].g == ($past(lo0_o[0]) && $past(lo1_o[0]))));
endmodule

bind paired_tlb tlb_chk #(.N_ENTRIES(N_ENTRIES)) u_tlb_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pr_hit(pr_hit), .pr_idx(pr_idx), .index_o(index_o), .hi_o(hi_o),
    .lo0_o(lo0_o), .lo1_o(lo1_o), .lk_miss(lk_miss),
    .lk_invalid(lk_invalid), .lk_dirty(lk_dirty), .ents(ents)
);

// File: tb/test_paired_tlb.sv
module test_paired_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  asid;
        logic        miss;
        logic        inv;
        logic        dirty;
        logic [2:0]  cattr;
        logic [31:0] pa;
    } lk_vec_t;

    localparam lk_vec_t VECS [10] = '{
        '{va: 32'h00400123, asid: 8'h05, miss: 1'b0, inv: 1'b0, dirty: 1'b1, cattr: 3'd3, pa: 32'h12345123},
        '{va: 32'h00401FFF, asid: 8'h05, miss: 1'b0, inv: 1'b0, dirty: 1'b0, cattr: 3'd2, pa: 32'h00ABCFFF},
        '{va: 32'h00400123, asid: 8'h06, miss: 1'b1, inv: 1'b0, dirty: 1'b0, cattr: 3'd0, pa: 32'h0},
        '{va: 32'h10002345, asid: 8'h33, miss: 1'b0, inv: 1'b0, dirty: 1'b0, cattr: 3'd0, pa: 32'h00202345},
        '{va: 32'h10005678, asid: 8'h33, miss: 1'b0, inv: 1'b1, dirty: 1'b1, cattr: 3'd0, pa: 32'h0},
        '{va: 32'h10008000, asid: 8'h09, miss: 1'b1, inv: 1'b0, dirty: 1'b0, cattr: 3'd0, pa: 32'h0},
        '{va: 32'h10003FFF, asid: 8'h09, miss: 1'b0, inv: 1'b0, dirty: 1'b0, cattr: 3'd0, pa: 32'h00203FFF},
        '{va: 32'h20000010, asid: 8'h12, miss: 1'b1, inv: 1'b0, dirty: 1'b0, cattr: 3'd0, pa: 32'h0},
        '{va: 32'h20000010, asid: 8'h11, miss: 1'b0, inv: 1'b0, dirty: 1'b0, cattr: 3'd0, pa: 32'h00055010},
        '{va: 32'h00000ABC, asid: 8'h00, miss: 1'b0, inv: 1'b1, dirty: 1'b0, cattr: 3'd0, pa: 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  slot_idx = '0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic [31:0] hi_o, lo0_o, lo1_o, mask_o, index_o, lk_paddr;
    logic        lk_miss, lk_invalid, lk_dirty;
    logic [2:0]  lk_cattr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    paired_tlb #(.N_ENTRIES(N)) i_paired_tlb (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .slot_idx(slot_idx), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .hi_o(hi_o), .lo0_o(lo0_o), .lo1_o(lo1_o), .mask_o(mask_o),
        .index_o(index_o), .lk_paddr(lk_paddr), .lk_miss(lk_miss),
        .lk_invalid(lk_invalid), .lk_dirty(lk_dirty), .lk_cattr(lk_cattr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic csr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic stage(input logic [31:0] hi, lo0, lo1, msk);
        csr(3'd0, hi); csr(3'd1, lo0); csr(3'd2, lo1); csr(3'd3, msk);
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] asid);
        @(negedge clk);
        lk_vaddr = va; lk_asid = asid;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        lookup(32'h0, 8'h0);
        chk("R1 index", index_o, 32'h0);
        chk("R1 hi", hi_o, 32'h0);
        chk("R1 miss", {31'b0, lk_miss}, 32'h0);
        chk("R1 invalid", {31'b0, lk_invalid}, 32'h1);
        cmd(2'd2);
        chk("R1 probe zero tag", index_o, 32'h0);

        // setup: R2 indexed writes, R3 slot write
        stage(32'h00400005, 32'h0048D15E, 32'h0002AF12, 32'h0);
        csr(3'd4, 32'h0); cmd(2'd0);
        stage(32'h10000009, 32'h00008003, 32'h0000C005, 32'h00006000);
        slot_idx = 4'd7; cmd(2'd1);
        stage(32'h20000011, 32'h00001543, 32'h00001582, 32'h0);
        csr(3'd4, 32'h2); cmd(2'd0);
        stage(32'h00400005, 32'h01DDDDC2, 32'h0, 32'h0);
        csr(3'd4, 32'h3); cmd(2'd0);

        // lookup table: R4 R5 R6 R10 R11
        for (int i = 0; i < 10; i++) begin
            lookup(VECS[i].va, VECS[i].asid);
            chk($sformatf("R10 miss row %0d", i), {31'b0, lk_miss}, {31'b0, VECS[i].miss});
            chk($sformatf("R6 invalid row %0d", i), {31'b0, lk_invalid}, {31'b0, VECS[i].inv});
            chk($sformatf("R5 dirty row %0d", i), {31'b0, lk_dirty}, {31'b0, VECS[i].dirty});
            if (!VECS[i].miss && !VECS[i].inv) begin
                chk($sformatf("R5 cattr row %0d", i), {29'b0, lk_cattr}, {29'b0, VECS[i].cattr});
                chk($sformatf("R11 paddr row %0d", i), lk_paddr, VECS[i].pa);
            end
        end

        // R7 probe hit and lowest index on duplicate tags
        csr(3'd0, 32'h20000011); cmd(2'd2);
        chk("R7 probe hit", index_o, 32'h2);
        csr(3'd0, 32'h00400005); cmd(2'd2);
        chk("R7 probe lowest", index_o, 32'h0);

        // R8 probe miss keeps number, sets bit 31
        csr(3'd4, 32'h5);
        csr(3'd0, 32'h30000001); cmd(2'd2);
        chk("R8 probe miss", index_o, 32'h80000005);

        // R9 / R3 read back the slot-written entry
        csr(3'd4, 32'h7); cmd(2'd3);
        chk("R3 R9 hi", hi_o, 32'h10000009);
        chk("R9 mask", mask_o, 32'h00006000);
        chk("R9 lo0", lo0_o, 32'h00008003);
        chk("R9 lo1", lo1_o, 32'h0000C005);

        // R2 index masked to entry count
        csr(3'd4, 32'h13);
        chk("R2 index masked", index_o, 32'h3);
        cmd(2'd3);
        chk("R2 read hi", hi_o, 32'h00400005);
        chk("R2 read lo0", lo0_o, 32'h01DDDDC2);
        chk("R2 read lo1", lo1_o, 32'h0);

        // R12 lookup in the same cycle as overwrite of entry 0
        stage(32'h60000001, 32'h00000002, 32'h0, 32'h0);
        csr(3'd4, 32'h0);
        @(negedge clk);
        lk_vaddr = 32'h00400123; lk_asid = 8'h05;
        cmd_valid = 1'b1; cmd_op = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R12 old contents", lk_paddr, 32'h12345123);
        @(negedge clk);
        chk("R12 new winner", lk_paddr, 32'h77777123);
        chk("R12 hit", {31'b0, lk_miss}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule